// File: doc/BRIEF.md
# Clock Mode Controller

This block sits in front of the phase detector of a clock-generation core and decides which of four operating modes the core runs in. Two reference monitors (primary and secondary) each deliver multi-bit binary phase-error words with a one-cycle valid strobe. Each monitor also raises a holdover request when it loses confidence in its reference. The controller forwards the chosen monitor's words to the phase detector and tracks the loop filter's frequency-correction words while the loop is locked. It drives the correction the core should apply.

The external mode command picks free-run, locked operation or a forced holdover. In locked operation, the committed monitor can push the core into an automatic holdover state on its own, and the core leaves that state when the request drops. During either holdover the controller supplies a frozen correction. This value is the average of the last N correction words accepted while locked. In free-run the correction is zero, so the core runs on its master oscillator alone.

The phase word path is a valid-only stream with no back-pressure. The phase detector takes every word it is offered, and each monitor strobe is a complete word. The controller never stalls a monitor. Words that arrive outside locked mode, or from the monitor that is not committed, are dropped.

Top module: `clk_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `mode_o` is 00 (free-run), `phase_valid_o` is 0 and `corr_o` is 0. The committed monitor is the primary, and the correction history holds N zero words.
- R2: A `mode_cmd` of 00 puts `mode_o` at 00 after the next clock edge, whatever the monitor requests are. While `mode_o` is 00, `corr_o` is 0.
- R3: A `mode_cmd` of 01 or 11 gives `mode_o` 01 (normal) after the next edge when the committed monitor's holdover request is low.
- R4: A `mode_cmd` of 01 or 11 gives `mode_o` 11 (automatic holdover) after the next edge when the committed monitor's holdover request is high. The block returns to 01 on the edge after that request clears. The request of the monitor that is not committed has no effect.
- R5: A `mode_cmd` of 10 gives `mode_o` 10 (external holdover) after the next edge, whatever the monitor requests are. The block stays there until `mode_cmd` changes.
- R6: When a strobe from the committed monitor arrives while `mode_o` is 01, the same word appears on `phase_o` with `phase_valid_o` high one cycle later. In any other mode, no word is forwarded.
- R7: `ref_sel` (0 primary, 1 secondary) is committed only in a cycle where the monitor it names strobes, and that word is the first one forwarded from it. Until then, words and holdover requests from the previously committed monitor stay in use.
- R8: A correction word accepted with `corr_valid` while `mode_o` is 01 appears on `corr_o` after the next edge and enters the N-deep history.
- R9: On the edge where the mode moves from 01 to 10 or 11, `corr_o` becomes floor(sum of the last N accepted words / N), using two's-complement signed arithmetic. It stays constant for as long as the mode remains 10 or 11.
- R10: Correction words offered while `mode_o` is not 01 are ignored. They change neither the history nor the value shown on return to 01, which is the last word accepted in 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pri_phase | input | W | Primary monitor phase-error word |
| pri_valid | input | 1 | Primary word strobe |
| pri_hold | input | 1 | Primary monitor holdover request |
| sec_phase | input | W | Secondary monitor phase-error word |
| sec_valid | input | 1 | Secondary word strobe |
| sec_hold | input | 1 | Secondary monitor holdover request |
| ref_sel | input | 1 | Requested monitor, 0 primary, 1 secondary |
| mode_cmd | input | 2 | 00 free-run, 10 forced holdover, 01/11 locked with automatic holdover |
| corr_in | input | CW | Signed frequency-correction word from the loop filter |
| corr_valid | input | 1 | Correction word strobe |
| mode_o | output | 2 | 00 free-run, 01 normal, 10 holdover, 11 automatic holdover |
| phase_o | output | W | Forwarded phase word |
| phase_valid_o | output | 1 | Forwarded word strobe |
| corr_o | output | CW | Signed correction in use |

## Verification
The assertions take for granted that the mode command and both holdover requests are known in every cycle after reset. They also assume a freshly entered holdover is not re-entered from locked mode without passing through it. The stable-correction property relies on holdover moves between 10 and 11 never reloading the frozen value. The bench drives every input away from the clock edge and holds `mode_cmd` and the requests steady for at least one full cycle. It never offers a correction word in the cycle that leaves locked mode, so each frozen average is defined by the words that came before.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_NORM = 2'b01,
    MODE_HOLD = 2'b10,
    MODE_AUTO = 2'b11
  } ckm_mode_e;

  localparam logic [1:0] CMD_FREE = 2'b00;
  localparam logic [1:0] CMD_HOLD = 2'b10;

  function automatic logic is_holdover(input ckm_mode_e m);
    return (m == MODE_HOLD) || (m == MODE_AUTO);
  endfunction
endpackage

// File: rtl/ckm_mode_fsm.sv
module ckm_mode_fsm
  import ckm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_cmd,
  input  logic       sel_hold,
  output ckm_mode_e  mode_q,
  output logic       enter_hold
);
  ckm_mode_e mode_nxt;

  always_comb begin
    case (mode_cmd)
      CMD_FREE: mode_nxt = MODE_FREE;
      CMD_HOLD: mode_nxt = MODE_HOLD;
      default:  mode_nxt = sel_hold ? MODE_AUTO : MODE_NORM;
    endcase
  end

  assign enter_hold = (mode_q == MODE_NORM) && is_holdover(mode_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_FREE;
    else        mode_q <= mode_nxt;
  end
endmodule

// File: rtl/ckm_phase_sel.sv
module ckm_phase_sel #(
  parameter int W    = 16,
  parameter int NMON = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NMON-1:0][W-1:0] mon_word,
  input  logic [NMON-1:0]      mon_valid,
  input  logic [NMON-1:0]      mon_hold,
  input  logic [$clog2(NMON)-1:0] sel_req,
  input  logic                 fwd_en,
  output logic                 sel_hold,
  output logic [W-1:0]         word_q,
  output logic                 valid_q
);
  localparam int SW = $clog2(NMON);

  logic [SW-1:0] sel_q;
  logic [SW-1:0] sel_nxt;
  logic          fire;

  assign sel_nxt  = mon_valid[sel_req] ? sel_req : sel_q;
  assign fire     = fwd_en && mon_valid[sel_nxt];
  assign sel_hold = mon_hold[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sel_q   <= sel_nxt;
      valid_q <= fire;
      if (fire) word_q <= mon_word[sel_nxt];
    end
  end
endmodule

// File: rtl/ckm_hist_avg.sv
module ckm_hist_avg #(
  parameter int CW    = 16,
  parameter int LOG_N = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic signed [CW-1:0] corr_in,
  input  logic                 freeze,
  output logic signed [CW-1:0] last_q,
  output logic signed [CW-1:0] hold_q
);
  localparam int N  = 1 << LOG_N;
  localparam int SW = CW + LOG_N;

  logic signed [CW-1:0] ring_q [N];
  logic [LOG_N-1:0]     ptr_q;
  logic signed [SW-1:0] sum_q;
  logic signed [CW-1:0] avg;

  assign avg = sum_q[SW-1:LOG_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ring_q[i] <= '0;
      ptr_q  <= '0;
      sum_q  <= '0;
      last_q <= '0;
    end else if (accept) begin
      ring_q[ptr_q] <= corr_in;
      ptr_q         <= ptr_q + LOG_N'(1);
      sum_q         <= sum_q + SW'(corr_in) - SW'(ring_q[ptr_q]);
      last_q        <= corr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (freeze) hold_q <= avg;
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import ckm_pkg::*;
#(
  parameter int W     = 16,
  parameter int CW    = 16,
  parameter int LOG_N = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         pri_phase,
  input  logic                 pri_valid,
  input  logic                 pri_hold,
  input  logic [W-1:0]         sec_phase,
  input  logic                 sec_valid,
  input  logic                 sec_hold,
  input  logic                 ref_sel,
  input  logic [1:0]           mode_cmd,
  input  logic signed [CW-1:0] corr_in,
  input  logic                 corr_valid,
  output logic [1:0]           mode_o,
  output logic [W-1:0]         phase_o,
  output logic                 phase_valid_o,
  output logic signed [CW-1:0] corr_o
);
  localparam int NMON = 2;

  ckm_mode_e              mode_q;
  logic                   enter_hold;
  logic                   sel_hold;
  logic [NMON-1:0][W-1:0] mon_word;
  logic [NMON-1:0]        mon_valid;
  logic [NMON-1:0]        mon_hold;
  logic signed [CW-1:0]   last_corr;
  logic signed [CW-1:0]   hold_corr;

  assign mon_word  = {sec_phase, pri_phase};
  assign mon_valid = {sec_valid, pri_valid};
  assign mon_hold  = {sec_hold, pri_hold};

  ckm_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_cmd   (mode_cmd),
    .sel_hold   (sel_hold),
    .mode_q     (mode_q),
    .enter_hold (enter_hold)
  );

  ckm_phase_sel #(.W(W), .NMON(NMON)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_word  (mon_word),
    .mon_valid (mon_valid),
    .mon_hold  (mon_hold),
    .sel_req   (ref_sel),
    .fwd_en    (mode_q == MODE_NORM),
    .sel_hold  (sel_hold),
    .word_q    (phase_o),
    .valid_q   (phase_valid_o)
  );

  ckm_hist_avg #(.CW(CW), .LOG_N(LOG_N)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (corr_valid && (mode_q == MODE_NORM)),
    .corr_in (corr_in),
    .freeze  (enter_hold),
    .last_q  (last_corr),
    .hold_q  (hold_corr)
  );

  assign mode_o = mode_q;

  always_comb begin
    case (mode_q)
      MODE_FREE: corr_o = '0;
      MODE_NORM: corr_o = last_corr;
      default:   corr_o = hold_corr;
    endcase
  end
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pri_hold,
  input logic                 sec_hold,
  input logic [1:0]           mode_cmd,
  input logic [1:0]           mode_o,
  input logic                 phase_valid_o,
  input logic signed [CW-1:0] corr_o
);
  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (mode_o == 2'b00 && !phase_valid_o && corr_o == '0);
    end
  end

  p_free_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cmd == 2'b00 |=> (mode_o == 2'b00 && corr_o == '0));

  p_auto_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmd[0] && pri_hold && sec_hold) |=> mode_o == 2'b11);

  p_auto_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && mode_cmd[0] && !pri_hold && !sec_hold) |=> mode_o == 2'b01);

  p_ext_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cmd == 2'b10 |=> mode_o == 2'b10);

  p_fwd_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid_o |-> $past(mode_o) == 2'b01);

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[1] && $past(mode_o[1])) |-> $stable(corr_o));
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk #(.W(W), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pri_hold      (pri_hold),
  .sec_hold      (sec_hold),
  .mode_cmd      (mode_cmd),
  .mode_o        (mode_o),
  .phase_valid_o (phase_valid_o),
  .corr_o        (corr_o)
);

// File: tb/clk_mode_ctrl_tb.sv
module clk_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int CW = 12;
  localparam int LN = 2;
  localparam int N  = 1 << LN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] pri_phase = '0, sec_phase = '0;
  logic pri_valid = 0, sec_valid = 0, pri_hold = 0, sec_hold = 0, ref_sel = 0;
  logic [1:0] mode_cmd = 2'b00;
  logic signed [CW-1:0] corr_in = '0;
  logic corr_valid = 0;
  logic [1:0] mode_o;
  logic [W-1:0] phase_o;
  logic phase_valid_o;
  logic signed [CW-1:0] corr_o;

  int n_chk = 0;
  int n_bad = 0;
  int hist [N];
  int hptr = 0;
  int last_acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_mode_ctrl #(.W(W), .CW(CW), .LOG_N(LN)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pri_phase(pri_phase), .pri_valid(pri_valid), .pri_hold(pri_hold),
    .sec_phase(sec_phase), .sec_valid(sec_valid), .sec_hold(sec_hold),
    .ref_sel(ref_sel), .mode_cmd(mode_cmd),
    .corr_in(corr_in), .corr_valid(corr_valid),
    .mode_o(mode_o), .phase_o(phase_o), .phase_valid_o(phase_valid_o),
    .corr_o(corr_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int hist_avg();
    int s = 0;
    for (int i = 0; i < N; i++) s += hist[i];
    return s >>> LN;
  endfunction

  task automatic pulse_mon(input logic which, input logic [W-1:0] w);
    if (which) begin sec_valid = 1; sec_phase = w; end
    else       begin pri_valid = 1; pri_phase = w; end
    tick();
    pri_valid = 0; sec_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) hist[i] = 0;
    tick(); tick();
    // R1: reset state
    check("R1 mode", mode_o, 0);
    check("R1 valid", phase_valid_o, 0);
    check("R1 corr", corr_o, 0);
    rst_n = 1;
    tick();
    check("R1 mode after release", mode_o, 0);
    check("R1 corr after release", corr_o, 0);

    // R2 R3 R4 R5: sweep of command and requests for each committed monitor
    for (int sel = 0; sel < 2; sel++) begin
      mode_cmd = 2'b01; pri_hold = 0; sec_hold = 0; ref_sel = sel[0];
      pulse_mon(sel[0], 8'h00);
      for (int cmd = 0; cmd < 4; cmd++)
        for (int ph = 0; ph < 2; ph++)
          for (int sh = 0; sh < 2; sh++) begin
            int exp;
            mode_cmd = cmd[1:0]; pri_hold = ph[0]; sec_hold = sh[0];
            tick();
            if (cmd == 0) exp = 0;
            else if (cmd == 2) exp = 2;
            else exp = ((sel == 1) ? sh : ph) ? 3 : 1;
            check((cmd == 0) ? "R2" : (cmd == 2) ? "R5" : (exp == 3) ? "R4" : "R3",
                  mode_o, exp);
            if (exp == 0) check("R2 corr zero", corr_o, 0);
          end
      // R4: automatic holdover left once request clears
      mode_cmd = 2'b01; pri_hold = 1; sec_hold = 1; tick();
      check("R4 enter", mode_o, 3);
      pri_hold = 0; sec_hold = 0; tick();
      check("R4 exit", mode_o, 1);
    end
    pri_hold = 0; sec_hold = 0;

    // R6: forwarding only in normal mode (committed monitor is secondary)
    for (int cmd = 0; cmd < 4; cmd++) begin
      mode_cmd = cmd[1:0]; tick();
      pulse_mon(1'b1, 8'(8'h30 + cmd));
      check("R6 fwd valid", phase_valid_o, (mode_o == 2'b01) ? 1 : 0);
      if (mode_o == 2'b01) check("R6 fwd word", phase_o, 8'h30 + cmd);
      tick();
      check("R6 strobe single", phase_valid_o, 0);
    end

    // R7: selection commit on strobe of requested monitor
    mode_cmd = 2'b01; tick();
    ref_sel = 0;
    pri_hold = 1; tick();
    check("R7 uncommitted hold ignored", mode_o, 1);
    pri_hold = 0;
    pulse_mon(1'b1, 8'hA1);
    check("R7 old monitor still forwarded", phase_o, 8'hA1);
    check("R7 old monitor valid", phase_valid_o, 1);
    pulse_mon(1'b0, 8'hB2);
    check("R7 first word of new monitor", phase_o, 8'hB2);
    pulse_mon(1'b1, 8'hC3);
    check("R7 old monitor dropped", phase_valid_o, 0);
    pri_hold = 1; tick();
    check("R7 new monitor hold in use", mode_o, 3);
    pri_hold = 0; tick();

    // R8 R9 R10: correction history
    for (int seq = 0; seq < 4; seq++) begin
      int cnt = 3 + seq * 2;
      int frozen;
      for (int i = 0; i < cnt; i++) begin
        int v = ((seq * 37 + i * 53) % 400) - 200;
        corr_valid = 1; corr_in = CW'(v);
        tick();
        check("R8 corr shown", corr_o, v);
        hist[hptr] = v; hptr = (hptr + 1) % N; last_acc = v;
      end
      corr_valid = 0;
      if (seq[0]) pri_hold = 1; else mode_cmd = 2'b10;
      tick();
      frozen = hist_avg();
      check("R9 mode", mode_o, seq[0] ? 3 : 2);
      check("R9 frozen avg", corr_o, frozen);
      for (int k = 0; k < 2; k++) begin
        corr_valid = 1; corr_in = CW'(700 + k); tick();
        check("R9 R10 hold stable", corr_o, frozen);
      end
      corr_valid = 0; pri_hold = 0; mode_cmd = 2'b01; tick();
      check("R10 last accepted kept", corr_o, last_acc);
      mode_cmd = 2'b10; tick();
      check("R10 history untouched", corr_o, frozen);
      mode_cmd = 2'b01; tick();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule